// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a bus target for a two-wire serial bus in the SMBus/I2C style. It holds a small register file of bytes and gives a host block access to it. The host first writes a starting index. On a write, the host then sends a length byte followed by that many data bytes, which are stored at consecutive locations. On a read, the host issues a repeated start and the read address after the index. The target then returns a length byte, taken from a fixed register slot, followed by register bytes in ascending order until the host stops acknowledging.

SCL and SDA arrive unsynchronised and are oversampled by the system clock through two-flop synchronisers. The target pulls SDA low through an open-drain enable and never drives it high. Start, repeated start and stop conditions are detected at any point in a transfer. A start or stop aborts whatever was in progress. The stored index survives a repeated start, so the index-then-read sequence works.

Top module: `smb_idx_target`

## Requirements
- R1: The 8-bit address byte 0xD2 (7-bit address 0x69, LSB 0 for write) and 0xD3 (LSB 1 for read) are acknowledged. Any other address byte is not acknowledged, and the target leaves SDA released for every following bit until the next start or stop.
- R2: In a write, the byte after the address is the index N and the next is the count X. Each of these is acknowledged. The following X data bytes are each acknowledged and stored at locations N, N+1, and so on.
- R3: A data byte sent after X bytes have already been stored is not acknowledged and is not stored. Later bytes of the same transfer are also ignored.
- R4: In a read, after the read address is acknowledged, the first byte sent is the content of register slot 8. It is followed by the registers at N, N+1, ... in ascending order, each sent MSB first.
- R5: The running index wraps modulo 32, for both writes and reads.
- R6: When the host does not acknowledge a byte it reads, the target releases SDA and drives nothing until the next start or stop.
- R7: A stop or start seen in the middle of a byte abandons that byte without storing it. A repeated start keeps the index last written.
- R8: The SDA drive enable only changes while the synchronised SCL is low.
- R9: After reset all 32 registers read as zero and SDA is released.
- R10: A write with count X = 0 stores nothing, and its first data byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired level) |
| sda_oe | output | 1 | When 1, pull SDA low; when 0, release it |

## Verification
The assertions assume a well-behaved host. It moves SDA only while SCL is low, except when it forms a start or a stop. It never tries a start or stop while the target holds SDA low. It keeps every SCL phase longer than the three-cycle synchroniser and edge-detect latency. The bench models the bus as a wired AND of the host and the target. Its host changes SCL and SDA on separate six-cycle quarter periods and only issues start and stop when the target has released the line. Under those rules, SDA only changes while SCL is low, and the ignore state never drives.

// File: rtl/smb_idx_target.sv
module smb_idx_target #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREGS    = 32,
  parameter int         LEN_SLOT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int IW = $clog2(NREGS);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_IDX, ST_CNT, ST_WR, ST_RD, ST_IGN} st_t;

  logic [1:0]    scl_q, sda_q;
  logic          scl_d, sda_d;
  st_t           st;
  logic [2:0]    bitcnt;
  logic [7:0]    sh;
  logic          full, in_ack, rw, host_nak;
  logic [IW-1:0] idx;
  logic [7:0]    rem;
  logic [7:0]    regs [NREGS];

  wire scl_s     = scl_q[1];
  wire sda_s     = sda_q[1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire bus_start = scl_s & scl_d & sda_d & ~sda_s;
  wire bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
  wire addr_hit  = (sh[7:1] == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= 3'd0;
      sh       <= 8'd0;
      full     <= 1'b0;
      in_ack   <= 1'b0;
      rw       <= 1'b0;
      host_nak <= 1'b0;
      idx      <= '0;
      rem      <= 8'd0;
      sda_oe   <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= 8'd0;
    end else if (bus_start || bus_stop) begin
      st     <= bus_start ? ST_ADDR : ST_IDLE;
      bitcnt <= 3'd0;
      full   <= 1'b0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_IGN: ;
        ST_RD: begin
          if (scl_rise && in_ack) host_nak <= sda_s;
          if (scl_fall) begin
            if (in_ack) begin
              in_ack <= 1'b0;
              if (host_nak) begin
                st     <= ST_IGN;
                sda_oe <= 1'b0;
              end else begin
                sh     <= regs[idx];
                sda_oe <= ~regs[idx][7];
                idx    <= idx + 1'b1;
                bitcnt <= 3'd0;
              end
            end else if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              in_ack <= 1'b1;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
              bitcnt <= bitcnt + 3'd1;
            end
          end
        end
        default: begin
          if (scl_rise && !in_ack) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) full <= 1'b1;
          end else if (scl_fall && full) begin
            full   <= 1'b0;
            in_ack <= 1'b1;
            case (st)
              ST_ADDR: begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                end else begin
                  st <= ST_IGN;
                end
              end
              ST_IDX: begin
                idx    <= sh[IW-1:0];
                sda_oe <= 1'b1;
              end
              ST_CNT: begin
                rem    <= sh;
                sda_oe <= 1'b1;
              end
              default: begin
                if (rem != 8'd0) begin
                  regs[idx] <= sh;
                  idx       <= idx + 1'b1;
                  rem       <= rem - 8'd1;
                  sda_oe    <= 1'b1;
                end else begin
                  st <= ST_IGN;
                end
              end
            endcase
          end else if (scl_fall && in_ack) begin
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
            bitcnt <= 3'd0;
            case (st)
              ST_ADDR: begin
                if (rw) begin
                  st     <= ST_RD;
                  sh     <= regs[LEN_SLOT];
                  sda_oe <= ~regs[LEN_SLOT][7];
                end else begin
                  st <= ST_IDX;
                end
              end
              ST_IDX:  st <= ST_CNT;
              ST_CNT:  st <= ST_WR;
              default: st <= ST_WR;
            endcase
          end
        end
      endcase
    end
  end

  a_r8_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  a_r6_ignore_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN) |-> !sda_oe);

  a_r5_index_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR && $past(st) == ST_WR && idx != $past(idx)) |-> idx == IW'($past(idx) + 1'b1));

  a_r3_count_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR && $past(st) == ST_WR) |-> rem <= $past(rem));

  a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_start) |-> (st == ST_ADDR && !sda_oe));

endmodule

// File: tb/test_smb_idx_target.sv
module test_smb_idx_target;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_scl = 1'b1;
  logic h_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [7:0] mdl [32];
  int n_chk = 0, n_fail = 0, viol = 0;
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_bus = h_sda & ~sda_oe;

  smb_idx_target i_smb_idx_target (
    .clk(clk), .rst_n(rst_n), .scl_i(h_scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  always @(negedge clk) begin
    if (sda_oe != prev_oe && h_scl) viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    h_sda = b; tick(Q); h_scl = 1'b1; tick(2*Q); h_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    h_sda = 1'b1; tick(Q); h_scl = 1'b1; tick(Q); b = sda_bus; tick(Q); h_scl = 1'b0; tick(Q);
  endtask

  task automatic go_start();
    h_sda = 1'b1; tick(Q); h_scl = 1'b1; tick(Q); h_sda = 1'b0; tick(Q); h_scl = 1'b0; tick(Q);
  endtask

  task automatic go_stop();
    h_sda = 1'b0; tick(Q); h_scl = 1'b1; tick(Q); h_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!give_ack);
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic do_write(input int n, input int x, input int nb, input int seed, input string tag);
    logic a;
    go_start();
    send_byte(8'hD2, a); chk(a, "R1 write address ack", a, 1);
    send_byte(8'(n), a); chk(a, "R2 index ack", a, 1);
    send_byte(8'(x), a); chk(a, "R2 count ack", a, 1);
    for (int k = 0; k < nb; k++) begin
      logic [7:0] d;
      d = pat(seed, k);
      send_byte(d, a);
      chk(a == (k < x), tag, a, int'(k < x));
      if (k < x) mdl[(n + k) % 32] = d;
    end
    go_stop();
  endtask

  task automatic do_read(input int n, input int len, input string tag);
    logic a, b;
    logic [7:0] d;
    int ones;
    go_start();
    send_byte(8'hD2, a); chk(a, "R1 write address ack", a, 1);
    send_byte(8'(n), a); chk(a, "R2 index ack", a, 1);
    go_start();
    send_byte(8'hD3, a); chk(a, "R1 read address ack", a, 1);
    recv_byte(d, 1'b1); chk(d == mdl[8], "R4 length byte from slot 8", d, mdl[8]);
    for (int k = 0; k < len; k++) begin
      recv_byte(d, k < len - 1);
      chk(d == mdl[(n + k) % 32], tag, d, mdl[(n + k) % 32]);
    end
    ones = 0;
    for (int k = 0; k < 9; k++) begin
      get_bit(b);
      ones += int'(b);
    end
    chk(ones == 9, "R6 released after host NACK", ones, 9);
    go_stop();
  endtask

  initial begin
    logic a;
    for (int i = 0; i < 32; i++) mdl[i] = 8'd0;
    tick(5);
    chk(sda_oe == 1'b0, "R9 SDA released in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R9 SDA released after reset", sda_oe, 0);
    do_read(0, 32, "R9 register zero after reset");

    do_write(0, 32, 32, 1, "R2 full fill");
    do_write(30, 5, 5, 2, "R5 write wrap");
    for (int n = 0; n < 32; n++) do_read(n, 3, (n >= 30) ? "R5 read wrap" : "R4 ascending data");

    do_write(4, 2, 4, 4, "R3 excess byte nacked");
    do_read(4, 4, "R3 excess byte not stored");

    do_write(12, 0, 2, 5, "R10 zero count nacks");
    do_read(12, 2, "R10 nothing stored");

    go_start();
    send_byte(8'hA4, a); chk(!a, "R1 foreign address nacked", a, 0);
    send_byte(8'h0C, a); chk(!a, "R1 ignored after mismatch", a, 0);
    send_byte(8'h5A, a); chk(!a, "R1 ignored after mismatch", a, 0);
    go_stop();
    do_read(12, 1, "R1 registers untouched");

    go_start();
    send_byte(8'hD2, a); chk(a, "R7 address ack", a, 1);
    send_byte(8'd5, a);  chk(a, "R7 index ack", a, 1);
    send_byte(8'd3, a);  chk(a, "R7 count ack", a, 1);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    go_stop();
    do_read(5, 1, "R7 aborted byte not stored");
    do_read(17, 2, "R7 index kept across repeated start");

    chk(viol == 0, "R8 drive changed with SCL high", viol, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule